// File: doc/BRIEF.md
# Dual-Bank Ping-Pong SRAM FIFO Controller

This block turns two external SRAM banks, each one 64-bit word wide, into a single first-in first-out buffer. Producers push 64-bit words through a valid/ready port. A 32-bit consumer pulls the data back out as dwords through a second valid/ready port, strictly in arrival order. The block drives the chip-enable, write-enable, output-enable, address and write-data pins of both banks. It also keeps the read and write word pointers, a fill count and the full and empty flags.

Successive words are interleaved across the banks. Bit 0 of a word pointer selects the bank, and the remaining pointer bits form the in-bank address. As a result, a write to one bank can overlap a read from the other. The SRAM access time is longer than one core cycle, so every access holds its strobes for `HOLD_CYC` cycles. Each 64-bit read supplies two dwords, which halves the number of memory reads the consumer needs.

With the default `BANK_AW` of 17, each bank holds 128K words and the buffer holds 2 MB in total.

Top module: `pingpong_sram_fifo`

## Requirements
- R1: While reset is held, the block shows `empty`=1, `full`=0, `fill_count`=0 and `rd_valid`=0, and every bank strobe (`sram_ce_n`, `sram_we_n`, `sram_oe_n`) is high.
- R2: Dwords leave in arrival order. Each 64-bit word gives bits [31:0] first and bits [63:32] second. A dword is transferred when `rd_valid` and `rd_ready` are both high at a clock edge.
- R3: The k-th word written (counting from 0 after reset) goes to bank k mod 2 at in-bank address (k/2) mod 2^BANK_AW, and the k-th word read comes from the same place. Bank 0 uses the low `BANK_AW` bits of `sram_addr` and the low 64 bits of the data buses; bank 1 uses the high slices.
- R4: Each access drives its bank's `sram_ce_n` low for exactly `HOLD_CYC` consecutive cycles, with the address held steady. The strobes are `sram_we_n` for a write and `sram_oe_n` for a read.
- R5: A bank never carries a read and a write at the same time. When a new read and a new write want the same idle bank in one cycle, the write starts and the read waits.
- R6: A write on one bank and a read on the other bank can be in progress in the same cycle.
- R7: `fill_count` equals the number of words accepted minus the number of words whose SRAM read has started. `full` is high when the count is 2·2^BANK_AW. While `full` is high, `wr_ready` is low and offered words are not stored.
- R8: While the buffer is empty, no read access starts and `rd_valid` stays low once the output word has been drained.
- R9: Only one write is in progress at a time: `wr_ready` is low while any bank's `sram_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A 64-bit word is offered |
| wr_data | input | WORD_W | Offered word |
| wr_ready | output | 1 | Block accepts the offered word at this edge |
| rd_valid | output | 1 | A dword is available |
| rd_data | output | WORD_W/2 | Current dword |
| rd_ready | input | 1 | Consumer takes the current dword |
| fill_count | output | BANK_AW+2 | Words stored and not yet fetched |
| full | output | 1 | Buffer at capacity |
| empty | output | 1 | No stored word left to fetch |
| sram_ce_n | output | 2 | Chip enable per bank, active low |
| sram_we_n | output | 2 | Write enable per bank, active low |
| sram_oe_n | output | 2 | Output enable per bank, active low |
| sram_addr | output | 2*BANK_AW | In-bank address, bank 1 in the high slice |
| sram_wdata | output | 2*WORD_W | Write data, bank 1 in the high slice |
| sram_rdata | input | 2*WORD_W | Read data from the banks, bank 1 in the high slice |

## Verification
The bench first fills the buffer with the consumer stalled. Because the output holding word has already taken one word out of the count, exactly 2·depth+1 words must be accepted before `full` rises. A design that counts the holding word, or that stops one short, shows up here as a wrong acceptance count. Next the bench keeps offering a word while `full` is high; if a design stores that word anyway, it appears later as an extra dword in the drained stream. Random traffic at several producer and consumer rates forces read and write requests to collide on the same bank. A design without the bank interlock would overlap write and read strobes on one bank, or would pick the wrong bank and address for a word, and the per-access pin monitor reports both. Finally, a drained, idle buffer must start no read strobe.

// File: rtl/pp_fifo_pkg.sv
// Shared definitions for the ping-pong SRAM FIFO.
// Assumes exactly two banks, selected by bit 0 of a word pointer.
package pp_fifo_pkg;
    localparam int NBANK = 2;

    typedef enum logic {
        BANK_L = 1'b0,
        BANK_R = 1'b1
    } bank_e;

    // Bank that holds the word a pointer refers to.
    function automatic bank_e bank_of(input logic ptr_lsb);
        return bank_e'(ptr_lsb);
    endfunction
endpackage

// File: rtl/pp_access_seq.sv
// Access sequencer: once started, it holds one SRAM access open for HOLD_CYC
// cycles and exposes the latched bank and in-bank address.
// Assumes start is raised only while busy is low.
module pp_access_seq
    import pp_fifo_pkg::*;
#(
    parameter int PTR_W    = 18,
    parameter int HOLD_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PTR_W-1:0]     ptr,
    output logic                 busy,
    output logic                 last,
    output bank_e                bank,
    output logic [PTR_W-2:0]     addr
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic [CW-1:0]    cnt_q;
    logic [PTR_W-1:0] ptr_q;

    // Track the open access and its cycle within the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            ptr_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            ptr_q <= ptr;
        end else if (last) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = busy && (cnt_q == CW'(HOLD_CYC - 1));
    assign bank = bank_of(ptr_q[0]);
    assign addr = ptr_q[PTR_W-1:1];
endmodule

// File: rtl/pp_bank_port.sv
// Bank pin driver: routes the write and read sequencers to the pins of the
// bank each one owns. Assumes the arbiter never gives both the same bank.
module pp_bank_port
    import pp_fifo_pkg::*;
#(
    parameter int BANK_AW = 17,
    parameter int WORD_W  = 64
) (
    input  logic                      w_busy,
    input  bank_e                     w_bank,
    input  logic [BANK_AW-1:0]        w_addr,
    input  logic [WORD_W-1:0]         w_data,
    input  logic                      r_busy,
    input  bank_e                     r_bank,
    input  logic [BANK_AW-1:0]        r_addr,
    output logic [NBANK-1:0]          ce_n,
    output logic [NBANK-1:0]          we_n,
    output logic [NBANK-1:0]          oe_n,
    output logic [NBANK*BANK_AW-1:0]  addr,
    output logic [NBANK*WORD_W-1:0]   wdata
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam bank_e THIS_BANK = (g == 1) ? BANK_R : BANK_L;
        logic wsel;
        logic rsel;

        // Decide which sequencer, if any, owns this bank now.
        assign wsel = w_busy && (w_bank == THIS_BANK);
        assign rsel = r_busy && (r_bank == THIS_BANK);

        assign ce_n[g] = !(wsel || rsel);
        assign we_n[g] = !wsel;
        assign oe_n[g] = !rsel;
        assign addr[g*BANK_AW +: BANK_AW] = wsel ? w_addr : r_addr;
        assign wdata[g*WORD_W +: WORD_W]  = w_data;
    end
endmodule

// File: rtl/pp_dword_unpack.sv
// Output unpacker: holds one 64-bit word and hands it to the consumer as
// two dwords, low half first. Assumes load arrives only while rd_valid is low.
module pp_dword_unpack #(
    parameter int WORD_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [WORD_W-1:0]     din,
    input  logic                  rd_ready,
    output logic                  rd_valid,
    output logic [WORD_W/2-1:0]   rd_data
);
    localparam int DW = WORD_W / 2;

    logic [WORD_W-1:0] word_q;
    logic              upper_q;

    // Load a fetched word and step through its halves as they are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            upper_q  <= 1'b0;
            word_q   <= '0;
        end else if (load) begin
            rd_valid <= 1'b1;
            upper_q  <= 1'b0;
            word_q   <= din;
        end else if (rd_valid && rd_ready) begin
            if (upper_q) begin
                rd_valid <= 1'b0;
                upper_q  <= 1'b0;
            end else begin
                upper_q  <= 1'b1;
            end
        end
    end

    assign rd_data = upper_q ? word_q[WORD_W-1:DW] : word_q[DW-1:0];
endmodule

// File: rtl/pingpong_sram_fifo.sv
// Ping-pong SRAM FIFO top: interleaves words over two SRAM banks, arbitrates
// bank ownership between one writer and one reader (write first), and keeps
// the pointers, fill count and flags. Assumes SRAMs that write on a low
// chip enable plus low write enable, and drive data on a low output enable.
module pingpong_sram_fifo
    import pp_fifo_pkg::*;
#(
    parameter int BANK_AW  = 17,
    parameter int WORD_W   = 64,
    parameter int HOLD_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [WORD_W-1:0]         wr_data,
    output logic                      wr_ready,
    output logic                      rd_valid,
    output logic [WORD_W/2-1:0]       rd_data,
    input  logic                      rd_ready,
    output logic [BANK_AW+1:0]        fill_count,
    output logic                      full,
    output logic                      empty,
    output logic [NBANK-1:0]          sram_ce_n,
    output logic [NBANK-1:0]          sram_we_n,
    output logic [NBANK-1:0]          sram_oe_n,
    output logic [NBANK*BANK_AW-1:0]  sram_addr,
    output logic [NBANK*WORD_W-1:0]   sram_wdata,
    input  logic [NBANK*WORD_W-1:0]   sram_rdata
);
    localparam int PTR_W = BANK_AW + 1;
    localparam int CNT_W = BANK_AW + 2;
    localparam logic [CNT_W-1:0] CAP = CNT_W'(1) << PTR_W;

    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [WORD_W-1:0] wdata_q;

    logic              wr_go;
    logic              rd_go;
    logic              w_busy;
    logic              w_last;
    bank_e             w_bank;
    logic [BANK_AW-1:0] w_addr;
    logic              r_busy;
    logic              r_last;
    bank_e             r_bank;
    logic [BANK_AW-1:0] r_addr;
    logic [WORD_W-1:0] fetched;

    assign full       = (count_q == CAP);
    assign empty      = (count_q == '0);
    assign fill_count = count_q;

    // A bank is free when its chip enable is inactive.
    assign wr_ready = !full && !w_busy && sram_ce_n[wr_ptr_q[0]];
    assign wr_go    = wr_valid && wr_ready;

    // Reader starts only into an empty holder; a same-bank write wins.
    assign rd_go = !r_busy && !rd_valid && !empty
                && sram_ce_n[rd_ptr_q[0]]
                && !(wr_go && (wr_ptr_q[0] == rd_ptr_q[0]));

    // Pointer, count and write-data bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            wdata_q  <= '0;
        end else begin
            if (wr_go) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
                wdata_q  <= wr_data;
            end
            if (rd_go) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            case ({wr_go, rd_go})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    pp_access_seq #(.PTR_W(PTR_W), .HOLD_CYC(HOLD_CYC)) u_wseq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_go),
        .ptr   (wr_ptr_q),
        .busy  (w_busy),
        .last  (w_last),
        .bank  (w_bank),
        .addr  (w_addr)
    );

    pp_access_seq #(.PTR_W(PTR_W), .HOLD_CYC(HOLD_CYC)) u_rseq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rd_go),
        .ptr   (rd_ptr_q),
        .busy  (r_busy),
        .last  (r_last),
        .bank  (r_bank),
        .addr  (r_addr)
    );

    pp_bank_port #(.BANK_AW(BANK_AW), .WORD_W(WORD_W)) u_port (
        .w_busy (w_busy),
        .w_bank (w_bank),
        .w_addr (w_addr),
        .w_data (wdata_q),
        .r_busy (r_busy),
        .r_bank (r_bank),
        .r_addr (r_addr),
        .ce_n   (sram_ce_n),
        .we_n   (sram_we_n),
        .oe_n   (sram_oe_n),
        .addr   (sram_addr),
        .wdata  (sram_wdata)
    );

    // Select the data bus of the bank being read.
    assign fetched = (r_bank == BANK_R) ? sram_rdata[NBANK*WORD_W-1:WORD_W]
                                        : sram_rdata[WORD_W-1:0];

    pp_dword_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (r_last),
        .din      (fetched),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/pingpong_sram_fifo_chk.sv
// Property checker for pingpong_sram_fifo, attached by bind. It observes the
// ports and the sequencer outputs and has no effect on the design.
module pingpong_sram_fifo_chk
    import pp_fifo_pkg::*;
#(
    parameter int BANK_AW = 17
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_ready,
    input logic                      full,
    input logic                      empty,
    input logic [BANK_AW+1:0]        fill_count,
    input logic [NBANK-1:0]          sram_ce_n,
    input logic [NBANK-1:0]          sram_we_n,
    input logic [NBANK-1:0]          sram_oe_n,
    input logic [NBANK*BANK_AW-1:0]  sram_addr,
    input logic                      w_busy,
    input logic                      r_busy,
    input bank_e                     w_bank,
    input bank_e                     r_bank
);
    localparam logic [BANK_AW+1:0] CAP = (BANK_AW+2)'(1) << (BANK_AW + 1);

    logic we0_q, we1_q, seen_w, last_w1;

    // Remember which bank took the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we0_q   <= 1'b1;
            we1_q   <= 1'b1;
            seen_w  <= 1'b0;
            last_w1 <= 1'b0;
        end else begin
            we0_q <= sram_we_n[0];
            we1_q <= sram_we_n[1];
            if (we0_q && !sram_we_n[0]) begin
                seen_w  <= 1'b1;
                last_w1 <= 1'b0;
            end else if (we1_q && !sram_we_n[1]) begin
                seen_w  <= 1'b1;
                last_w1 <= 1'b1;
            end
        end
    end

    AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_busy && r_busy && (w_bank == r_bank))); // R5
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_ready); // R7
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CAP); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R7
    AST_NO_READ_WHEN_EMPTY_L: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n[0]) |-> $past(!empty)); // R8
    AST_NO_READ_WHEN_EMPTY_R: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n[1]) |-> $past(!empty)); // R8
    AST_STROBE_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_ce_n[0]) |=> (!sram_ce_n[0] && $stable(sram_addr[BANK_AW-1:0]))); // R4
    AST_STROBE_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_ce_n[1]) |=> (!sram_ce_n[1] && $stable(sram_addr[2*BANK_AW-1:BANK_AW]))); // R4
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        w_busy |-> !wr_ready); // R9
    AST_ALTERNATE_L: assert property (@(posedge clk) disable iff (!rst_n)
        (we0_q && !sram_we_n[0]) |-> (!seen_w || last_w1)); // R3
    AST_ALTERNATE_R: assert property (@(posedge clk) disable iff (!rst_n)
        (we1_q && !sram_we_n[1]) |-> (!seen_w || !last_w1)); // R3
endmodule

bind pingpong_sram_fifo pingpong_sram_fifo_chk #(.BANK_AW(BANK_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .full       (full),
    .empty      (empty),
    .fill_count (fill_count),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_addr  (sram_addr),
    .w_busy     (w_busy),
    .r_busy     (r_busy),
    .w_bank     (w_bank),
    .r_bank     (r_bank)
);

// File: tb/test_pingpong_sram_fifo.sv
module test_pingpong_sram_fifo;
    localparam int BANK_AW  = 3;
    localparam int WORD_W   = 64;
    localparam int HOLD_CYC = 2;
    localparam int DEPTH    = 1 << BANK_AW;
    localparam int CAP      = 2 * DEPTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                    wr_valid = 1'b0;
    logic [WORD_W-1:0]       wr_data = '0;
    logic                    wr_ready;
    logic                    rd_valid;
    logic [WORD_W/2-1:0]     rd_data;
    logic                    rd_ready = 1'b0;
    logic [BANK_AW+1:0]      fill_count;
    logic                    full, empty;
    logic [1:0]              sram_ce_n, sram_we_n, sram_oe_n;
    logic [2*BANK_AW-1:0]    sram_addr;
    logic [2*WORD_W-1:0]     sram_wdata;
    logic [2*WORD_W-1:0]     sram_rdata;

    pingpong_sram_fifo #(.BANK_AW(BANK_AW), .WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) i_pingpong_sram_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ready(rd_ready), .fill_count(fill_count), .full(full), .empty(empty),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    // Simple SRAM model for both banks.
    logic [WORD_W-1:0] mem [2][DEPTH];
    always @(posedge clk) begin
        for (int b = 0; b < 2; b++)
            if (!sram_ce_n[b] && !sram_we_n[b])
                mem[b][sram_addr[b*BANK_AW +: BANK_AW]] <= sram_wdata[b*WORD_W +: WORD_W];
    end
    always_comb begin
        for (int b = 0; b < 2; b++)
            sram_rdata[b*WORD_W +: WORD_W] = (!sram_ce_n[b] && !sram_oe_n[b])
                ? mem[b][sram_addr[b*BANK_AW +: BANK_AW]] : '0;
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] pattern(input int idx);
        logic [31:0] lo;
        lo = 32'(idx) * 32'h9E37_79B1 + 32'h0000_1357;
        return {lo ^ 32'hFFFF_0000 ^ 32'(idx << 4), lo};
    endfunction

    // Monitor state
    int acc = 0, rd_started = 0, wstart = 0, rstart = 0, conc = 0;
    logic [31:0] exp_q[$];
    bit ce_prev [2] = '{1'b1, 1'b1};
    int lowcnt [2] = '{0, 0};
    logic [BANK_AW-1:0] addr_st [2];
    bit mon_en = 1'b0;

    // Drive write data for the next word to be offered.
    always @(negedge clk) wr_data <= pattern(acc);

    // Sample 2 ns before each rising edge.
    always begin
        @(negedge clk);
        #8;
        if (mon_en) begin
            for (int b = 0; b < 2; b++) begin
                logic ce_now;
                logic [BANK_AW-1:0] ab;
                ce_now = sram_ce_n[b];
                ab = sram_addr[b*BANK_AW +: BANK_AW];
                if (ce_prev[b] && !ce_now) begin
                    lowcnt[b] = 1;
                    addr_st[b] = ab;
                    if (!sram_we_n[b]) begin
                        check(b == wstart % 2, "R3", 64'(b), 64'(wstart % 2));
                        check(ab == BANK_AW'((wstart / 2) % DEPTH), "R3", 64'(ab), 64'((wstart / 2) % DEPTH));
                        wstart++;
                    end else begin
                        check(b == rstart % 2, "R3", 64'(b), 64'(rstart % 2));
                        check(ab == BANK_AW'((rstart / 2) % DEPTH), "R3", 64'(ab), 64'((rstart / 2) % DEPTH));
                        rstart++;
                        rd_started++;
                    end
                end else if (!ce_now) begin
                    lowcnt[b]++;
                    check(ab == addr_st[b], "R4", 64'(ab), 64'(addr_st[b]));
                end
                if (!ce_prev[b] && ce_now)
                    check(lowcnt[b] == HOLD_CYC, "R4", 64'(lowcnt[b]), 64'(HOLD_CYC));
                if (!sram_we_n[b] && !sram_oe_n[b])
                    check(1'b0, "R5", {sram_we_n, sram_oe_n}, 64'hF);
                ce_prev[b] = ce_now;
            end
            if ((!sram_we_n[0] && !sram_oe_n[1]) || (!sram_we_n[1] && !sram_oe_n[0]))
                conc++;
            check(int'(fill_count) == acc - rd_started, "R7", 64'(fill_count), 64'(acc - rd_started));
            if (full) check(!wr_ready, "R7", 64'(wr_ready), 64'd0);
            if (sram_we_n != 2'b11) check(!wr_ready, "R9", 64'(wr_ready), 64'd0);
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", 64'(rd_data), 64'd0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R2", 64'(rd_data), 64'(e));
                end
            end
            if (wr_valid && wr_ready) begin
                exp_q.push_back(wr_data[31:0]);
                exp_q.push_back(wr_data[63:32]);
                acc++;
            end
        end
    end

    task automatic drain();
        wr_valid = 1'b0;
        rd_ready = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !rd_valid && empty) break;
        end
        #5;
        check(exp_q.size() == 0, "R2", 64'(exp_q.size()), 64'd0);
        check(empty && fill_count == 0, "R8", 64'(fill_count), 64'd0);
    endtask

    task automatic run_main();
        int base;
        int pw [6] = '{20, 60, 95, 40, 90, 10};
        int pr [6] = '{90, 30, 50, 95, 85, 70};
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk); #5;
        // R1 reset state
        check(empty == 1'b1 && full == 1'b0, "R1", {full, empty}, 64'b01);
        check(fill_count == 0 && !rd_valid, "R1", 64'(fill_count), 64'd0);
        check(sram_ce_n == 2'b11 && sram_we_n == 2'b11 && sram_oe_n == 2'b11, "R1",
              {sram_ce_n, sram_we_n, sram_oe_n}, 64'h3F);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // Single word, R2 ordering
        wr_valid = 1'b1;
        while (acc < 1) @(negedge clk);
        drain();

        // Fill to capacity with consumer stalled (R7)
        base = acc;
        rd_ready = 1'b0;
        wr_valid = 1'b1;
        repeat (120) @(negedge clk);
        #5;
        check(acc - base == CAP + 1, "R7", 64'(acc - base), 64'(CAP + 1));
        check(full == 1'b1, "R7", 64'(full), 64'd1);
        check(fill_count == CAP, "R7", 64'(fill_count), 64'(CAP));
        check(wr_ready == 1'b0, "R7", 64'(wr_ready), 64'd0);
        check(rd_valid && rd_data == pattern(base)[31:0], "R2", 64'(rd_data), 64'(pattern(base)[31:0]));
        // Offers while full are ignored (R7)
        repeat (10) @(negedge clk);
        #5;
        check(acc - base == CAP + 1, "R7", 64'(acc - base), 64'(CAP + 1));
        drain();

        // Idle empty buffer (R8)
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #5;
            check(!rd_valid && sram_oe_n == 2'b11, "R8", {rd_valid, sram_oe_n}, 64'h3);
        end

        // Random traffic segments
        for (int s = 0; s < 6; s++) begin
            repeat (500) begin
                @(negedge clk);
                wr_valid = ($urandom % 100) < pw[s];
                rd_ready = ($urandom % 100) < pr[s];
            end
        end
        drain();
        check(conc > 0, "R6", 64'(conc), 64'd1);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule